// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block carries single read and write transfers from an 8-bit processor core onto an external multiplexed bus. The low address byte and the data byte take turns on one set of eight bidirectional lines. The high address byte has dedicated output lines. External parts latch the low address on the falling edge of an address strobe. They then respond to an active-low read strobe or an active-low write strobe. A slow device can pull an active-low wait input to make the strobe longer. The block also produces a free-running bus clock output.

The sequencer runs on a clock at twice the oscillator frequency, so one clock cycle ("tick") is half an oscillator cycle. Every bus phase is a whole number of ticks, set by parameters.

The core starts a transfer with a one-tick `req`, together with `addr`, `wdata` and `wr`. When the transfer is over, the block returns `rdata` and a one-tick `done`.

The controller moves through these states:
- IDLE→ADDR on request.
- ADDR→HOLD when the address strobe time has elapsed.
- HOLD→STROBE after the address hold.
- STROBE→STROBE (extend) when wait is low at the last strobe tick.
- STROBE→FINISH otherwise.
- FINISH→IDLE after one tick.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is asserted, the block holds the bus idle: `ale` is low, `rd_n` and `wr_n` are high, the `ad` lines are released (high impedance), `done` is low and `bclk` is high.
- R2: `bclk` repeats every 8 ticks, with 4 ticks high followed by 4 ticks low.
- R3: The tick after a request is accepted, `ale` goes high and stays high for 2 ticks. During that time `ad` carries `addr[7:0]` and `a_hi` carries `addr[15:8]`.
- R4: After `ale` falls, `ad` keeps driving `addr[7:0]` for 1 more tick with both strobes still high. The strobe falls on the tick that follows.
- R5: In a read, `rd_n` is low for 4 ticks and the block releases `ad` for the whole strobe.
- R6: In a write, `wr_n` is low for 4 ticks. `wdata` is on `ad` for all of the strobe and for 1 tick after `wr_n` rises.
- R7: `wait_n` is sampled only on the last tick of the strobe window. If it is low there, the strobe stays low for 8 more ticks, and `wait_n` is sampled again at the end of those ticks.
- R8: Read data is taken from `ad` on the clock edge where `rd_n` rises. That value appears on `rdata` in the tick where `done` is high.
- R9: `done` goes high for exactly one tick, in the tick right after the strobe rises. This holds for both reads and writes.
- R10: A `req` that arrives while a transfer is in progress is ignored and does not start a later transfer.
- R11: `rd_n` and `wr_n` are never low at the same time, and neither is low while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a transfer (sampled in IDLE) |
| addr | input | 16 | Transfer address |
| wdata | input | 8 | Write data |
| wr | input | 1 | 1 = write, 0 = read |
| rdata | output | 8 | Captured read data, valid with done |
| done | output | 1 | One-tick completion pulse |
| wait_n | input | 1 | Active-low wait from the external device |
| ad | inout | 8 | Shared low address / data lines |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| bclk | output | 1 | Free-running bus clock output |

## Verification
Two events share the last tick of the strobe: the wait sample, and the read capture together with the strobe release. The bench drives `wait_n` low exactly on that tick. It loads one byte on the bus before the sample and a different byte during the extension. The expected result is that the strobe stays low for another 8 ticks, `done` stays low, and the byte finally captured is the one present when the strobe actually rises. The earlier byte must not be captured.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_STROBE,
        ST_FINISH
    } xbus_state_t;
endpackage

// File: rtl/xbus_clkgen.sv
module xbus_clkgen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk
);
    localparam int CW   = $clog2(DIV);
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        if (cnt == CW'(DIV - 1)) cnt_nxt = '0;
        else                     cnt_nxt = cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bclk <= 1'b1;
        end else begin
            cnt  <= cnt_nxt;
            bclk <= (cnt_nxt < CW'(HALF));
        end
    end

    // R2: a high phase lasts longer than one tick
    a_r2_high_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |=> bclk);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int DW         = 8,
    parameter int AW         = 16,
    parameter int ADDR_TICKS = 2,
    parameter int HOLD_TICKS = 1,
    parameter int STB_TICKS  = 4,
    parameter int EXT_TICKS  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    input  logic          wait_n,
    input  logic [DW-1:0] ad_in,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic [AW-DW-1:0] a_hi,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [DW-1:0] rdata,
    output logic          done
);
    localparam int MAXT = (EXT_TICKS > STB_TICKS) ? EXT_TICKS : STB_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    xbus_state_t   state;
    logic [CW-1:0] cnt;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic          lat_wr;
    logic [DW-1:0] rdata_q;

    // state register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req) begin
                    state <= ST_ADDR;
                    cnt   <= CW'(ADDR_TICKS - 1);
                end
                ST_ADDR: if (cnt == '0) begin
                    state <= ST_HOLD;
                    cnt   <= CW'(HOLD_TICKS - 1);
                end else cnt <= cnt - 1'b1;
                ST_HOLD: if (cnt == '0) begin
                    state <= ST_STROBE;
                    cnt   <= CW'(STB_TICKS - 1);
                end else cnt <= cnt - 1'b1;
                ST_STROBE: if (cnt == '0) begin
                    if (!wait_n) cnt <= CW'(EXT_TICKS - 1);
                    else         state <= ST_FINISH;
                end else cnt <= cnt - 1'b1;
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // request latch and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_wr    <= 1'b0;
            rdata_q   <= '0;
        end else begin
            if (state == ST_IDLE && req) begin
                lat_addr  <= addr;
                lat_wdata <= wdata;
                lat_wr    <= wr;
            end
            if (state == ST_STROBE && cnt == '0 && wait_n && !lat_wr)
                rdata_q <= ad_in;
        end
    end

    // outputs
    always_comb begin
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        ad_oe  = 1'b0;
        ad_out = lat_addr[DW-1:0];
        done   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ADDR: begin
                ale   = 1'b1;
                ad_oe = 1'b1;
            end
            ST_HOLD: ad_oe = 1'b1;
            ST_STROBE: begin
                rd_n   = lat_wr;
                wr_n   = !lat_wr;
                ad_oe  = lat_wr;
                ad_out = lat_wdata;
            end
            ST_FINISH: begin
                ad_oe  = lat_wr;
                ad_out = lat_wdata;
                done   = 1'b1;
            end
            default: ;
        endcase
    end

    assign a_hi  = lat_addr[AW-1:DW];
    assign rdata = rdata_q;

    a_r11_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n) && !(ale && (!rd_n || !wr_n)));
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (rd_n && wr_n && ad_oe));
    a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    a_r8_rise_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> done);
    a_r6_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> ad_oe);
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
    parameter int DW         = 8,
    parameter int AW         = 16,
    parameter int ADDR_TICKS = 2,
    parameter int HOLD_TICKS = 1,
    parameter int STB_TICKS  = 4,
    parameter int BCLK_DIV   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    output logic [DW-1:0] rdata,
    output logic          done,
    input  logic          wait_n,
    inout  wire  [DW-1:0] ad,
    output logic [AW-DW-1:0] a_hi,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          bclk
);
    logic [DW-1:0] ad_out;
    logic          ad_oe;

    assign ad = ad_oe ? ad_out : {DW{1'bz}};

    xbus_clkgen #(.DIV(BCLK_DIV)) u_clk (
        .clk  (clk),
        .rst_n(rst_n),
        .bclk (bclk)
    );

    xbus_seq #(
        .DW(DW), .AW(AW), .ADDR_TICKS(ADDR_TICKS), .HOLD_TICKS(HOLD_TICKS),
        .STB_TICKS(STB_TICKS), .EXT_TICKS(BCLK_DIV)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .addr  (addr),
        .wdata (wdata),
        .wr    (wr),
        .wait_n(wait_n),
        .ad_in (ad),
        .ale   (ale),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .a_hi  (a_hi),
        .ad_out(ad_out),
        .ad_oe (ad_oe),
        .rdata (rdata),
        .done  (done)
    );
endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr = 1'b0;
    logic        wait_n = 1'b1;
    logic [7:0]  rdata;
    logic        done, ale, rd_n, wr_n, bclk;
    logic [7:0]  a_hi;
    wire  [7:0]  ad;
    logic        mem_drv = 1'b0;
    logic [7:0]  mem_val = '0;

    int checks = 0;
    int errors = 0;

    assign ad = mem_drv ? mem_val : 8'hzz;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wdata(wdata),
        .wr(wr), .rdata(rdata), .done(done), .wait_n(wait_n), .ad(ad),
        .a_hi(a_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .bclk(bclk)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic test_reset();
        chk("R1 ale", {15'd0, ale}, 16'd0);
        chk("R1 rd_n", {15'd0, rd_n}, 16'd1);
        chk("R1 wr_n", {15'd0, wr_n}, 16'd1);
        chk("R1 ad released", {8'd0, ad}, {8'd0, 8'hzz});
        chk("R1 done", {15'd0, done}, 16'd0);
        chk("R1 bclk", {15'd0, bclk}, 16'd1);
    endtask

    task automatic test_bclk();
        logic [15:0] v;
        for (int i = 0; i < 16; i++) begin
            v[i] = bclk;
            tick();
        end
        chk("R2 duty", 16'($countones(v)), 16'd8);
        for (int i = 0; i < 8; i++) begin
            chk("R2 period", {15'd0, v[i]}, {15'd0, v[i+8]});
            if (i < 4) chk("R2 half", {15'd0, v[i]}, {15'd0, ~v[i+4]});
        end
    endtask

    task automatic test_read(input logic [15:0] a, input logic [7:0] d, input bit stretch);
        addr = a; wr = 1'b0; req = 1'b1;
        tick();
        req = 1'b0;
        chk("R3 ale high", {15'd0, ale}, 16'd1);
        chk("R3 ad low addr", {8'd0, ad}, {8'd0, a[7:0]});
        chk("R3 a_hi", {8'd0, a_hi}, {8'd0, a[15:8]});
        tick();
        chk("R3 ale second tick", {15'd0, ale}, 16'd1);
        tick();
        chk("R4 ale low", {15'd0, ale}, 16'd0);
        chk("R4 addr held", {8'd0, ad}, {8'd0, a[7:0]});
        chk("R4 rd_n still high", {15'd0, rd_n}, 16'd1);
        tick();
        chk("R5 rd_n low", {15'd0, rd_n}, 16'd0);
        chk("R5 ad released", {8'd0, ad}, {8'd0, 8'hzz});
        mem_drv = 1'b1;
        mem_val = stretch ? ~d : d;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R5 rd_n held", {15'd0, rd_n}, 16'd0);
        end
        if (stretch) begin
            wait_n = 1'b0;
            tick();
            wait_n = 1'b1;
            mem_val = d;
            chk("R7 strobe extended", {15'd0, rd_n}, 16'd0);
            chk("R7 no done", {15'd0, done}, 16'd0);
            for (int i = 0; i < 7; i++) begin
                tick();
                chk("R7 extension rd_n", {15'd0, rd_n}, 16'd0);
                chk("R7 extension done", {15'd0, done}, 16'd0);
            end
        end
        tick();
        mem_drv = 1'b0;
        chk("R5 rd_n risen", {15'd0, rd_n}, 16'd1);
        chk("R9 done pulse", {15'd0, done}, 16'd1);
        chk("R8 rdata", {8'd0, rdata}, {8'd0, d});
        tick();
        chk("R9 done single", {15'd0, done}, 16'd0);
    endtask

    task automatic test_write(input logic [15:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1; req = 1'b1;
        tick();
        req = 1'b0;
        chk("R3 write ale", {15'd0, ale}, 16'd1);
        chk("R3 write a_hi", {8'd0, a_hi}, {8'd0, a[15:8]});
        tick();
        tick();
        chk("R4 write addr held", {8'd0, ad}, {8'd0, a[7:0]});
        chk("R4 write wr_n high", {15'd0, wr_n}, 16'd1);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R6 wr_n low", {15'd0, wr_n}, 16'd0);
            chk("R6 data driven", {8'd0, ad}, {8'd0, d});
            chk("R11 rd_n high", {15'd0, rd_n}, 16'd1);
            req = (i == 0);
        end
        req = 1'b0;
        tick();
        chk("R6 wr_n risen", {15'd0, wr_n}, 16'd1);
        chk("R6 data hold", {8'd0, ad}, {8'd0, d});
        chk("R9 write done", {15'd0, done}, 16'd1);
        tick();
        chk("R6 released after hold", {8'd0, ad}, {8'd0, 8'hzz});
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R10 busy req ignored", {14'd0, ale, done}, 16'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        tick();
        tick();
        test_bclk();
        test_read(16'hA53C, 8'h5A, 1'b0);
        tick();
        test_write(16'h12F0, 8'hC3);
        test_read(16'h7E81, 8'h96, 1'b1);
        test_write(16'hFF00, 8'h00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule